// File: doc/BRIEF.md
# GPIO Controller with Edge-Triggered Interrupts

A memory-mapped general-purpose I/O block for up to 32 pins, accessed over a plain 32-bit register bus. The bus has an address, a write strobe, write data and read data. Writes commit on the clock edge. Read data is combinational from the address, so it answers in the same cycle. Software picks each pin's direction and polarity inversion. Outputs are updated through atomic set, clear and toggle words, so no read-modify-write is needed. The synchronized, polarity-corrected pin levels can be read back.

Every pin can latch an interrupt on a rising edge, a falling edge or either edge, each through its own enable mask. Latched bits are cleared by writing 1 to them. A companion register records whether each latched event was a rising or a falling edge. All latched bits are ORed into a single interrupt line. The pin count is a parameter. A second parameter moves the data-side register block from base 0x10 to base 0x20.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset every register reads 0, `pin_oe_o` and `pin_o` are 0 and `irq_o` is 0.
- R2: The control words sit at fixed offsets: latched status 0x00, edge kind 0x04, rising-enable 0x08 and falling-enable 0x0C. Six data-side words follow in this order: data, direction, polarity, set, clear, toggle. They start at 0x10, or at 0x20 when `REG_GAP` is 1. Any other address reads 0.
- R3: A write to the set word drives the output bits under its 1s high, and a write to the clear word drives them low. Bits written as 0 keep their value. A write to the data word loads the output register directly.
- R4: A write to the toggle word inverts the output bits under its 1s and leaves the rest unchanged.
- R5: A direction bit of 1 makes the pin an output (`pin_oe_o` high). Reading the data word returns the output register for outputs. For inputs it returns the input level as seen after a two-flop synchronizer, which is two clock edges after the pin changes.
- R6: A polarity bit of 1 inverts both the driven value (`pin_o` = output register XOR polarity) and the level read back for an input.
- R7: A pin's status bit is set by a low-to-high change of its polarity-corrected level when its rising-enable bit is 1. It is set by a high-to-low change when its falling-enable bit is 1. The bit is visible three clock edges after the pin change. With both enable bits 0 the pin never latches.
- R8: When a status bit latches, the edge-kind bit of that pin records 1 for a rising edge and 0 for a falling edge.
- R9: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If a new enabled edge arrives in the same cycle as the clear, the bit stays set.
- R10: `irq_o` is 1 exactly when at least one status bit is set.
- R11: Register bits at and above `NUM_PINS` read as 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Byte address of the register word |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| pin_i | input | NUM_PINS | Pin levels from the pads (asynchronous) |
| pin_o | output | NUM_PINS | Value driven to the pads |
| pin_oe_o | output | NUM_PINS | Output enable per pin |
| irq_o | output | 1 | OR of all latched status bits |

## Verification
The bench builds the block with `NUM_PINS` = 12 and `REG_GAP` = 1. The reduced pin count leaves twenty unpopulated bits in every register, so all-ones writes can show that those bits read back as zero and that the atomic words cannot reach them. The shifted layout checks that the data-side words move to 0x20 and that the default-layout addresses then read as empty. Directed edge sequences cover each enable combination, the three-edge latency, the recorded edge kind, and a clear that meets a new edge in the same cycle.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam logic [7:0] OFS_STAT = 8'h00;
  localparam logic [7:0] OFS_KIND = 8'h04;
  localparam logic [7:0] OFS_RISE = 8'h08;
  localparam logic [7:0] OFS_FALL = 8'h0C;

  // word index inside the data-side block
  localparam int IDX_DATA = 0;
  localparam int IDX_DIR  = 1;
  localparam int IDX_POL  = 2;
  localparam int IDX_SET  = 3;
  localparam int IDX_CLR  = 4;
  localparam int IDX_TOG  = 5;

  function automatic logic [7:0] blk_addr(input bit gap, input int idx);
    logic [7:0] base;
    base = gap ? 8'h20 : 8'h10;
    return base + 8'(idx * 4);
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gpio_out_reg.sv
module gpio_out_reg #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic         tog_i,
  input  logic [W-1:0] wd_i,
  output logic [W-1:0] out_o
);
  logic [W-1:0] out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    out_q <= '0;
    else if (ld_i)  out_q <= wd_i;
    else if (set_i) out_q <= out_q | wd_i;
    else if (clr_i) out_q <= out_q & ~wd_i;
    else if (tog_i) out_q <= out_q ^ wd_i;
  end

  assign out_o = out_q;
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] rise_en_i,
  input  logic [W-1:0] fall_en_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] stat_o,
  output logic [W-1:0] kind_o,
  output logic [W-1:0] hit_o
);
  logic [W-1:0] prev_q, stat_q, kind_q;
  logic [W-1:0] rise, fall, hit;

  assign rise = lvl_i & ~prev_q;
  assign fall = ~lvl_i & prev_q;
  assign hit  = (rise & rise_en_i) | (fall & fall_en_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      stat_q <= '0;
      kind_q <= '0;
    end else begin
      prev_q <= lvl_i;
      // a new edge overrides a same-cycle clear
      stat_q <= (stat_q & ~clr_i) | hit;
      kind_q <= (kind_q & ~hit) | (rise & hit);
    end
  end

  assign stat_o = stat_q;
  assign kind_o = kind_q;
  assign hit_o  = hit;
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter bit REG_GAP  = 1'b0,
  parameter int ADDR_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] pin_o,
  output logic [NUM_PINS-1:0] pin_oe_o,
  output logic              irq_o
);
  localparam int NP = NUM_PINS;
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_KIND = ADDR_W'(OFS_KIND);
  localparam logic [ADDR_W-1:0] A_RISE = ADDR_W'(OFS_RISE);
  localparam logic [ADDR_W-1:0] A_FALL = ADDR_W'(OFS_FALL);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(blk_addr(REG_GAP, IDX_DATA));
  localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(blk_addr(REG_GAP, IDX_DIR));
  localparam logic [ADDR_W-1:0] A_POL  = ADDR_W'(blk_addr(REG_GAP, IDX_POL));
  localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(blk_addr(REG_GAP, IDX_SET));
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(blk_addr(REG_GAP, IDX_CLR));
  localparam logic [ADDR_W-1:0] A_TOG  = ADDR_W'(blk_addr(REG_GAP, IDX_TOG));

  logic [NP-1:0] wd;
  logic [NP-1:0] dir_q, pol_q, rise_en_q, fall_en_q;
  logic [NP-1:0] sync_lvl, lvl, out_q, stat_q, kind_q, hit, stat_clr;
  logic [NP-1:0] rd_np;

  assign wd = wdata_i[NP-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q     <= '0;
      pol_q     <= '0;
      rise_en_q <= '0;
      fall_en_q <= '0;
    end else if (we_i) begin
      if (addr_i == A_DIR)  dir_q     <= wd;
      if (addr_i == A_POL)  pol_q     <= wd;
      if (addr_i == A_RISE) rise_en_q <= wd;
      if (addr_i == A_FALL) fall_en_q <= wd;
    end
  end

  gpio_sync #(.W(NP)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (sync_lvl)
  );

  assign lvl = sync_lvl ^ pol_q;

  gpio_out_reg #(.W(NP)) i_out (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ld_i  (we_i && addr_i == A_DATA),
    .set_i (we_i && addr_i == A_SET),
    .clr_i (we_i && addr_i == A_CLR),
    .tog_i (we_i && addr_i == A_TOG),
    .wd_i  (wd),
    .out_o (out_q)
  );

  assign stat_clr = (we_i && addr_i == A_STAT) ? wd : '0;

  gpio_edge_irq #(.W(NP)) i_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lvl_i    (lvl),
    .rise_en_i(rise_en_q),
    .fall_en_i(fall_en_q),
    .clr_i    (stat_clr),
    .stat_o   (stat_q),
    .kind_o   (kind_q),
    .hit_o    (hit)
  );

  always_comb begin
    rd_np = '0;
    case (addr_i)
      A_STAT: rd_np = stat_q;
      A_KIND: rd_np = kind_q;
      A_RISE: rd_np = rise_en_q;
      A_FALL: rd_np = fall_en_q;
      A_DATA: rd_np = (dir_q & out_q) | (~dir_q & lvl);
      A_DIR:  rd_np = dir_q;
      A_POL:  rd_np = pol_q;
      default: rd_np = '0;
    endcase
  end

  generate
    if (NP < 32) begin : g_pad
      assign rdata_o = {{(32-NP){1'b0}}, rd_np};
    end else begin : g_full
      assign rdata_o = rd_np;
    end
  endgenerate

  assign pin_o    = out_q ^ pol_q;
  assign pin_oe_o = dir_q;
  assign irq_o    = |stat_q;
endmodule

// File: rtl/gpio_edge_chk.sv
module gpio_edge_chk
  import gpio_edge_pkg::*;
#(
  parameter int NP  = 32,
  parameter bit GAP = 1'b0,
  parameter int AW  = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] addr_i,
  input logic          we_i,
  input logic [31:0]   wdata_i,
  input logic [31:0]   rdata_o,
  input logic          irq_o,
  input logic [NP-1:0] out_i,
  input logic [NP-1:0] stat_i,
  input logic [NP-1:0] hit_i,
  input logic [NP-1:0] ren_i,
  input logic [NP-1:0] fen_i
);
  localparam logic [AW-1:0] C_STAT = AW'(OFS_STAT);
  localparam logic [AW-1:0] C_SET  = AW'(blk_addr(GAP, IDX_SET));
  localparam logic [AW-1:0] C_CLR  = AW'(blk_addr(GAP, IDX_CLR));
  localparam logic [AW-1:0] C_TOG  = AW'(blk_addr(GAP, IDX_TOG));

  assert_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == C_SET) |=>
      ((out_i & $past(wdata_i[NP-1:0])) == $past(wdata_i[NP-1:0])));

  assert_clr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == C_CLR) |=> ((out_i & $past(wdata_i[NP-1:0])) == '0));

  assert_tog_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == C_TOG) |=> (out_i == ($past(out_i) ^ $past(wdata_i[NP-1:0]))));

  assert_no_spurious_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((stat_i & ~$past(stat_i) & ~($past(ren_i) | $past(fen_i))) == '0));

  assert_w1c_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == C_STAT && ((wdata_i[NP-1:0] & hit_i) == '0)) |=>
      ((stat_i & $past(wdata_i[NP-1:0])) == '0));

  assert_edge_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|hit_i) |=> ((stat_i & $past(hit_i)) == $past(hit_i)));

  assert_irq_cause_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(|hit_i));

  generate
    if (NP < 32) begin : g_pad_chk
      assert_pad_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rdata_o[31:NP] == '0);
    end
  endgenerate
endmodule

bind gpio_edge_ctrl gpio_edge_chk #(.NP(NUM_PINS), .GAP(REG_GAP), .AW(ADDR_W)) i_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .addr_i (addr_i),
  .we_i   (we_i),
  .wdata_i(wdata_i),
  .rdata_o(rdata_o),
  .irq_o  (irq_o),
  .out_i  (out_q),
  .stat_i (stat_q),
  .hit_i  (hit),
  .ren_i  (rise_en_q),
  .fen_i  (fall_en_q)
);

// File: tb/test_gpio_edge_ctrl.sv
`timescale 1ns/1ps
module test_gpio_edge_ctrl;
  localparam int NP = 12;
  localparam logic [7:0] A_STAT = 8'h00, A_KIND = 8'h04, A_RISE = 8'h08, A_FALL = 8'h0C;
  localparam logic [7:0] A_DATA = 8'h20, A_DIR = 8'h24, A_POL = 8'h28;
  localparam logic [7:0] A_SET = 8'h2C, A_CLR = 8'h30, A_TOG = 8'h34;

  localparam int VN = 9;
  localparam logic [7:0]  V_ADDR [VN] = '{A_SET, A_SET, A_CLR, A_TOG, A_TOG, A_CLR, A_SET, A_DATA, A_CLR};
  localparam logic [31:0] V_WD   [VN] = '{32'h0F0, 32'h003, 32'h0F0, 32'hFFF, 32'h00C,
                                          32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h5A5, 32'h000};
  localparam logic [31:0] V_EXP  [VN] = '{32'h0F0, 32'h0F3, 32'h003, 32'hFFC, 32'hFF0,
                                          32'h000, 32'hFFF, 32'h5A5, 32'h5A5};

  logic clk = 1'b0, rst_n = 1'b0, we = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [NP-1:0] pin_in = '0, pin_out, pin_oe;
  logic irq;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gpio_edge_ctrl #(.NUM_PINS(NP), .REG_GAP(1'b1), .ADDR_W(8)) i_gpio_edge_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .pin_i(pin_in), .pin_o(pin_out), .pin_oe_o(pin_oe), .irq_o(irq)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; we = 1'b0; pin_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 50000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    do_reset();

    // R1 reset state
    rd(A_STAT, r); chk("R1", "status", r, 0);
    rd(A_KIND, r); chk("R1", "kind", r, 0);
    rd(A_RISE, r); chk("R1", "rise en", r, 0);
    rd(A_FALL, r); chk("R1", "fall en", r, 0);
    rd(A_DATA, r); chk("R1", "data", r, 0);
    rd(A_DIR,  r); chk("R1", "dir", r, 0);
    rd(A_POL,  r); chk("R1", "pol", r, 0);
    chk("R1", "pin_oe", 32'(pin_oe), 0);
    chk("R1", "pin_o", 32'(pin_out), 0);
    chk("R1", "irq", 32'(irq), 0);

    // R2 shifted layout, R5 direction to output enable
    wr(A_DIR, 32'h123);
    rd(A_DIR, r); chk("R2", "dir at gap offset", r, 32'h123);
    rd(8'h14, r); chk("R2", "default dir offset empty", r, 0);
    rd(8'h10, r); chk("R2", "default data offset empty", r, 0);
    chk("R5", "pin_oe follows dir", 32'(pin_oe), 32'h123);

    // R11 unpopulated bits
    wr(A_DIR, 32'hFFFF_FFFF);
    rd(A_DIR, r); chk("R11", "dir upper bits", r, 32'hFFF);
    wr(A_RISE, 32'hFFFF_F000);
    rd(A_RISE, r); chk("R11", "rise en upper bits", r, 0);

    // R3 R4 vector table: atomic output updates
    for (int i = 0; i < VN; i++) begin
      wr(V_ADDR[i], V_WD[i]);
      rd(A_DATA, r);
      chk(V_ADDR[i] == A_TOG ? "R4" : "R3", $sformatf("vector %0d data", i), r, V_EXP[i]);
      chk(V_ADDR[i] == A_TOG ? "R4" : "R3", $sformatf("vector %0d pin_o", i), 32'(pin_out), V_EXP[i]);
    end

    // R6 output polarity
    wr(A_DATA, 32'h0F0);
    wr(A_POL, 32'h00F);
    chk("R6", "pin_o inverted", 32'(pin_out), 32'h0FF);
    rd(A_DATA, r); chk("R5", "output data reads out reg", r, 32'h0F0);

    // R5 R6 input path
    do_reset();
    pin_in = 12'hA5A;
    wait_edges(1);
    rd(A_DATA, r); chk("R5", "input not yet synced", r, 0);
    wait_edges(1);
    rd(A_DATA, r); chk("R5", "input level", r, 32'hA5A);
    wr(A_POL, 32'h00F);
    rd(A_DATA, r); chk("R6", "input inverted", r, 32'hA55);

    // R7 R8 R10 edges
    do_reset();
    wr(A_RISE, 32'h050);
    wr(A_FALL, 32'h060);
    pin_in = 12'h0F0;
    wait_edges(2);
    rd(A_STAT, r); chk("R7", "latency not reached", r, 0);
    wait_edges(1);
    rd(A_STAT, r); chk("R7", "rising latch", r, 32'h050);
    rd(A_KIND, r); chk("R8", "rising kind", r, 32'h050);
    chk("R10", "irq set", 32'(irq), 1);

    // R9 write-1-to-clear
    wr(A_STAT, 32'h000);
    rd(A_STAT, r); chk("R9", "zero write keeps", r, 32'h050);
    wr(A_STAT, 32'h010);
    rd(A_STAT, r); chk("R9", "one write clears", r, 32'h040);

    pin_in = 12'h000;
    wait_edges(3);
    rd(A_STAT, r); chk("R7", "falling latch", r, 32'h060);
    rd(A_KIND, r); chk("R8", "falling kind", r & 32'h060, 0);

    wr(A_STAT, 32'hFFF);
    rd(A_STAT, r); chk("R9", "clear all", r, 0);
    chk("R10", "irq clear", 32'(irq), 0);

    // R9 edge meets clear in the same cycle
    pin_in = 12'h040;
    wait_edges(3);
    rd(A_STAT, r); chk("R7", "both-enabled rise", r, 32'h040);
    pin_in = 12'h000;
    @(posedge clk);
    @(posedge clk);
    wr(A_STAT, 32'h040);
    rd(A_STAT, r); chk("R9", "edge wins over clear", r, 32'h040);
    rd(A_KIND, r); chk("R8", "kind after fall", r & 32'h040, 0);
    wr(A_STAT, 32'h040);
    rd(A_STAT, r); chk("R9", "later clear", r, 0);

    // R7 disabled pins never latch
    wr(A_RISE, 0);
    wr(A_FALL, 0);
    pin_in = 12'hFFF;
    wait_edges(3);
    rd(A_STAT, r); chk("R7", "disabled rise", r, 0);
    pin_in = 12'h000;
    wait_edges(3);
    rd(A_STAT, r); chk("R7", "disabled fall", r, 0);
    chk("R10", "irq idle", 32'(irq), 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule